// File: doc/BRIEF.md
# Coprocessor Operand Register and Move Controller

This block holds the architectural state of an arithmetic coprocessor: four operand words (Left, Left-extension, Right, Right-extension), a 32-bit Control word, and the two result words (Result, Result-extension). The host reaches it over a shared data bus that carries one word in its first half-cycle (phase A) and one word in its second half-cycle (phase B). In this block the two halves are presented as two parallel input words, and the block's read data is a single output word. Each command carries a 4-bit move code and a function-write bit. The move code either loads registers from the bus, copies the result pair into an operand pair, or drives one register onto the phase-B data.

The arithmetic engine sits outside the block. It receives the operand and Control words and a one-cycle `eng_start` pulse, and later returns a result pair and exception flags with `eng_done`. Any write of operand or Control state restarts the engine. A command that reads a result is held off with `reject` until a result for the current state is available. When the read completes, the engine's exception flags are merged into the Control flags. If any merged flag is unmasked, `fault` is raised and the move is not carried out.

Top module: `cop_opreg_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared to zero. With no command present, `reject`, `fault` and `bus_b_oe` are low.
- R2: Move codes 0, 2 and 4 load Left, Right and Control, respectively, from `bus_b_in` at the clock edge.
- R3: Move codes 1, 3 and 5 load two words. Code 1 loads Left from `bus_b_in` and Left-extension from `bus_a_in`. Code 3 loads Right from B and Right-extension from A. Code 5 loads Left from B and Right from A.
- R4: Move codes 8, 9, 10, 11 and 12 drive Left, Left-extension, Right, Right-extension and Control, respectively, on `bus_b_out` with `bus_b_oe` high in the same cycle.
- R5: Control is laid out as Mask in bits 31:24, Flags in bits 23:16, Mode in bits 15:8 and Function in bits 7:0. When `cmd_wrfn` is set, `bus_a_in[7:0]` is written into Function and the other bits are unchanged. If the same command is move code 4, the full phase-B word is written instead.
- R6: With move codes 1, 3 or 5, `cmd_wrfn` is ignored and Function keeps its value.
- R7: A state write restarts the engine: `eng_start` is high in the cycle after the write. The state writes are move codes 0 to 5, a completed code 6 or 7, and a function write. A result read (move codes 6, 7, 14, 15) keeps `reject` high until a result computed after the latest restart has been returned. `reject` is never high for any other command.
- R8: Move codes 14 and 15 drive Result and Result-extension, once they are not rejected. These are the words returned by the engine for the current state.
- R9: Move codes 8 to 12 never assert `reject`. Move code 13 drives nothing and changes no register.
- R10: Move code 6 copies Result and Result-extension into Left and Left-extension. Move code 7 copies them into Right and Right-extension. Each copy restarts the engine.
- R11: When a result read is no longer rejected, the engine's flags are OR-ed into Control Flags. Flag bit 0 is Invalid, bit 2 is Overflow and bit 5 is Fixed-Divide-Overflow. Bits 6 and 7 are spare.
- R12: If the merged Flags AND Mask[5:0] is non-zero when a result read is no longer rejected, `fault` is high in that cycle. In that case `bus_b_oe` stays low and no operand is changed.
- R13: A function write that comes with a result read rejects that read, even if an older result is ready. The function write is not repeated while the command is held. The read completes with the result of the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present (held by the host while rejected) |
| cmd_code | input | 4 | Move code |
| cmd_wrfn | input | 1 | Write Function from phase-A data |
| bus_a_in | input | DW | Phase-A data from the host |
| bus_b_in | input | DW | Phase-B data from the host |
| bus_b_out | output | DW | Phase-B read data |
| bus_b_oe | output | 1 | Read data is valid this cycle |
| reject | output | 1 | Result not ready; host holds the command |
| fault | output | 1 | Unmasked exception flag on result read |
| eng_start | output | 1 | Restart pulse to the engine |
| eng_left | output | DW | Left operand to the engine |
| eng_leftx | output | DW | Left extension to the engine |
| eng_right | output | DW | Right operand to the engine |
| eng_rightx | output | DW | Right extension to the engine |
| eng_ctrl | output | DW | Control word to the engine |
| eng_done | input | 1 | Engine result valid |
| eng_result | input | DW | Result word from the engine |
| eng_resultx | input | DW | Result extension from the engine |
| eng_flags | input | FLAG_W | Exception flags from the engine |

## Verification
The bench builds the block with DW = 32 and FLAG_W = 6, which gives Control its four byte-wide fields and the full six-flag set. The masking and merge of the Overflow bit can therefore be checked against real byte positions. A behavioural engine in the bench returns Left+Right and Left-extension XOR Right-extension. Its latency is set per scenario, from one cycle up to eight, so that reject stalls of different lengths occur. Restarts caused by copies and by function writes can therefore be seen as a stall on the next result read.

// File: rtl/cop_opreg_pkg.sv
// Shared types for the coprocessor operand register block.
// Assumes a 4-bit move code; the code values are fixed by the host protocol.
package cop_opreg_pkg;

    typedef enum logic [2:0] {
        SRC_LEFT,
        SRC_LEFTX,
        SRC_RIGHT,
        SRC_RIGHTX,
        SRC_CTRL,
        SRC_RES,
        SRC_RESX,
        SRC_NONE
    } rd_src_e;

    // One decoded move command.
    typedef struct packed {
        logic    state_wr;     // codes 0..5 write operand/control state
        logic    ld_left_b;
        logic    ld_leftx_a;
        logic    ld_right_b;
        logic    ld_right_a;
        logic    ld_rightx_a;
        logic    ld_ctrl_b;
        logic    res_to_left;
        logic    res_to_right;
        logic    res_read;     // codes 6, 7, 14, 15
        logic    uses_a;       // phase-A data carries an operand
        logic    drive;        // word goes onto phase-B read data
        rd_src_e src;
    } move_dec_t;

endpackage

// File: rtl/cop_move_decode.sv
// Move-code decoder: turns the 4-bit move code into per-register load,
// copy and drive strobes. Purely combinational; assumes code is stable
// for the cycle it is used in.
module cop_move_decode
    import cop_opreg_pkg::*;
(
    input  logic [3:0] code,
    output move_dec_t  dec
);

    // Decode one move code into strobes.
    always_comb begin
        dec     = '0;
        dec.src = SRC_NONE;
        case (code)
            4'd0:  begin dec.state_wr = 1'b1; dec.ld_left_b  = 1'b1; end
            4'd1:  begin dec.state_wr = 1'b1; dec.ld_left_b  = 1'b1;
                         dec.ld_leftx_a = 1'b1; dec.uses_a = 1'b1; end
            4'd2:  begin dec.state_wr = 1'b1; dec.ld_right_b = 1'b1; end
            4'd3:  begin dec.state_wr = 1'b1; dec.ld_right_b = 1'b1;
                         dec.ld_rightx_a = 1'b1; dec.uses_a = 1'b1; end
            4'd4:  begin dec.state_wr = 1'b1; dec.ld_ctrl_b  = 1'b1; end
            4'd5:  begin dec.state_wr = 1'b1; dec.ld_left_b  = 1'b1;
                         dec.ld_right_a = 1'b1; dec.uses_a = 1'b1; end
            4'd6:  begin dec.res_read = 1'b1; dec.res_to_left  = 1'b1; end
            4'd7:  begin dec.res_read = 1'b1; dec.res_to_right = 1'b1; end
            4'd8:  begin dec.drive = 1'b1; dec.src = SRC_LEFT;   end
            4'd9:  begin dec.drive = 1'b1; dec.src = SRC_LEFTX;  end
            4'd10: begin dec.drive = 1'b1; dec.src = SRC_RIGHT;  end
            4'd11: begin dec.drive = 1'b1; dec.src = SRC_RIGHTX; end
            4'd12: begin dec.drive = 1'b1; dec.src = SRC_CTRL;   end
            4'd14: begin dec.res_read = 1'b1; dec.drive = 1'b1; dec.src = SRC_RES;  end
            4'd15: begin dec.res_read = 1'b1; dec.drive = 1'b1; dec.src = SRC_RESX; end
            default: ;
        endcase
    end

endmodule

// File: rtl/cop_operand_bank.sv
// Operand and Control registers. Loads from the two bus halves, copies
// of the result pair, Function-field writes and flag merges.
// Assumes the caller has already gated copies and merges with the
// reject/fault decision; a full Control load outranks field updates.
module cop_operand_bank
    import cop_opreg_pkg::*;
#(
    parameter int DW     = 32,
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  move_dec_t         dec,
    input  logic [DW-1:0]     bus_a,
    input  logic [DW-1:0]     bus_b,
    input  logic              do_copy,
    input  logic              fn_wr,
    input  logic              flag_merge,
    input  logic [DW-1:0]     result,
    input  logic [DW-1:0]     resultx,
    input  logic [FLAG_W-1:0] res_flags,
    output logic [DW-1:0]     left,
    output logic [DW-1:0]     leftx,
    output logic [DW-1:0]     right,
    output logic [DW-1:0]     rightx,
    output logic [DW-1:0]     ctrl
);

    localparam int LANE   = DW / 4;
    localparam int FN_LO  = 0;
    localparam int FLG_LO = 2 * LANE;

    // Left pair: bus loads, otherwise result copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            leftx <= '0;
        end else begin
            if (cmd_valid && dec.ld_left_b)        left  <= bus_b;
            else if (do_copy && dec.res_to_left)   left  <= result;
            if (cmd_valid && dec.ld_leftx_a)       leftx <= bus_a;
            else if (do_copy && dec.res_to_left)   leftx <= resultx;
        end
    end

    // Right pair: bus loads from either half, otherwise result copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            right  <= '0;
            rightx <= '0;
        end else begin
            if (cmd_valid && dec.ld_right_b)       right  <= bus_b;
            else if (cmd_valid && dec.ld_right_a)  right  <= bus_a;
            else if (do_copy && dec.res_to_right)  right  <= result;
            if (cmd_valid && dec.ld_rightx_a)      rightx <= bus_a;
            else if (do_copy && dec.res_to_right)  rightx <= resultx;
        end
    end

    // Control: full phase-B load wins over Function write and flag merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (cmd_valid && dec.ld_ctrl_b) begin
            ctrl <= bus_b;
        end else begin
            if (fn_wr)
                ctrl[FN_LO +: LANE] <= bus_a[FN_LO +: LANE];
            if (flag_merge)
                ctrl[FLG_LO +: FLAG_W] <= ctrl[FLG_LO +: FLAG_W] | res_flags;
        end
    end

endmodule

// File: rtl/cop_result_track.sv
// Result holder and restart sequencer. Issues a one-cycle start after
// each restart and after reset. Captures the engine's answer when it
// belongs to the current state.
// Assumes the engine abandons any computation when it sees a start pulse,
// so a done arriving with or before a start is stale.
module cop_result_track #(
    parameter int DW     = 32,
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              eng_done,
    input  logic [DW-1:0]     eng_result,
    input  logic [DW-1:0]     eng_resultx,
    input  logic [FLAG_W-1:0] eng_flags,
    output logic              start,
    output logic              ready,
    output logic [DW-1:0]     result,
    output logic [DW-1:0]     resultx,
    output logic [FLAG_W-1:0] res_flags
);

    // Start pulse; reset leaves one pending so the cleared state is computed.
    always_ff @(posedge clk) begin
        if (!rst_n) start <= 1'b1;
        else        start <= restart;
    end

    // Ready flag and captured result words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready     <= 1'b0;
            result    <= '0;
            resultx   <= '0;
            res_flags <= '0;
        end else if (restart) begin
            ready <= 1'b0;
        end else if (eng_done && !start) begin
            ready     <= 1'b1;
            result    <= eng_result;
            resultx   <= eng_resultx;
            res_flags <= eng_flags;
        end
    end

endmodule

// File: rtl/cop_opreg_ctrl.sv
// Top of the coprocessor operand register and move controller.
// Decides reject, fault, read data and restart for each command, and
// forwards the state to an external engine.
// Assumes the host holds a command unchanged while reject is high.
module cop_opreg_ctrl
    import cop_opreg_pkg::*;
#(
    parameter int DW     = 32,
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic              cmd_wrfn,
    input  logic [DW-1:0]     bus_a_in,
    input  logic [DW-1:0]     bus_b_in,
    output logic [DW-1:0]     bus_b_out,
    output logic              bus_b_oe,
    output logic              reject,
    output logic              fault,
    output logic              eng_start,
    output logic [DW-1:0]     eng_left,
    output logic [DW-1:0]     eng_leftx,
    output logic [DW-1:0]     eng_right,
    output logic [DW-1:0]     eng_rightx,
    output logic [DW-1:0]     eng_ctrl,
    input  logic              eng_done,
    input  logic [DW-1:0]     eng_result,
    input  logic [DW-1:0]     eng_resultx,
    input  logic [FLAG_W-1:0] eng_flags
);

    localparam int LANE   = DW / 4;
    localparam int FLG_LO = 2 * LANE;
    localparam int MSK_LO = 3 * LANE;

    move_dec_t         dec;
    logic [DW-1:0]     result, resultx;
    logic [FLAG_W-1:0] res_flags;
    logic              ready;
    logic              held_q;
    logic              rd_res, fn_wr, stall, fault_c, settle, do_copy, restart;
    logic [FLAG_W-1:0] merged, unmasked;

    cop_move_decode u_dec (
        .code (cmd_code),
        .dec  (dec)
    );

    // Command arbitration: stall, fault and restart decisions.
    always_comb begin
        rd_res   = cmd_valid && dec.res_read;
        fn_wr    = cmd_valid && cmd_wrfn && !dec.uses_a && !held_q;
        stall    = rd_res && (!ready || fn_wr);
        merged   = eng_ctrl[FLG_LO +: FLAG_W] | res_flags;
        unmasked = merged & eng_ctrl[MSK_LO +: FLAG_W];
        settle   = rd_res && !stall;
        fault_c  = settle && (|unmasked);
        do_copy  = settle && !fault_c && (dec.res_to_left || dec.res_to_right);
        restart  = (cmd_valid && dec.state_wr) || do_copy || fn_wr;
    end

    // Remember a rejected cycle so a held function write is not repeated.
    always_ff @(posedge clk) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= stall;
    end

    cop_operand_bank #(.DW(DW), .FLAG_W(FLAG_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .dec        (dec),
        .bus_a      (bus_a_in),
        .bus_b      (bus_b_in),
        .do_copy    (do_copy),
        .fn_wr      (fn_wr),
        .flag_merge (settle),
        .result     (result),
        .resultx    (resultx),
        .res_flags  (res_flags),
        .left       (eng_left),
        .leftx      (eng_leftx),
        .right      (eng_right),
        .rightx     (eng_rightx),
        .ctrl       (eng_ctrl)
    );

    cop_result_track #(.DW(DW), .FLAG_W(FLAG_W)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .eng_done    (eng_done),
        .eng_result  (eng_result),
        .eng_resultx (eng_resultx),
        .eng_flags   (eng_flags),
        .start       (eng_start),
        .ready       (ready),
        .result      (result),
        .resultx     (resultx),
        .res_flags   (res_flags)
    );

    // Read-data selection for the phase-B output.
    always_comb begin
        case (dec.src)
            SRC_LEFT:   bus_b_out = eng_left;
            SRC_LEFTX:  bus_b_out = eng_leftx;
            SRC_RIGHT:  bus_b_out = eng_right;
            SRC_RIGHTX: bus_b_out = eng_rightx;
            SRC_CTRL:   bus_b_out = eng_ctrl;
            SRC_RES:    bus_b_out = result;
            SRC_RESX:   bus_b_out = resultx;
            default:    bus_b_out = '0;
        endcase
    end

    assign bus_b_oe = cmd_valid && dec.drive && !stall && !fault_c;
    assign reject   = stall;
    assign fault    = fault_c;

endmodule

// File: rtl/cop_opreg_ctrl_chk.sv
// Property checker for cop_opreg_ctrl, attached by bind below.
module cop_opreg_ctrl_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [3:0]    cmd_code,
    input logic          bus_b_oe,
    input logic          reject,
    input logic          fault,
    input logic          eng_start,
    input logic [DW-1:0] eng_left,
    input logic [DW-1:0] eng_right
);

    logic is_res_code;
    assign is_res_code = (cmd_code == 4'd6) || (cmd_code == 4'd7) ||
                         (cmd_code == 4'd14) || (cmd_code == 4'd15);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (eng_left == '0) && (eng_right == '0));

    assert_reject_only_result_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> (cmd_valid && is_res_code));

    assert_write_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code <= 4'd5) |=> eng_start);

    assert_operand_read_no_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code >= 4'd8 && cmd_code <= 4'd12) |-> (!reject && bus_b_oe));

    assert_fault_no_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!bus_b_oe && !reject));

    assert_fault_no_move_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(eng_left) && $stable(eng_right)));

endmodule

bind cop_opreg_ctrl cop_opreg_ctrl_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .bus_b_oe  (bus_b_oe),
    .reject    (reject),
    .fault     (fault),
    .eng_start (eng_start),
    .eng_left  (eng_left),
    .eng_right (eng_right)
);

// File: tb/test_cop_opreg_ctrl.sv
// Directed bench for cop_opreg_ctrl with a behavioural engine.
module test_cop_opreg_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int FLAG_W     = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [3:0]        cmd_code = '0;
    logic              cmd_wrfn = 1'b0;
    logic [DW-1:0]     bus_a_in = '0;
    logic [DW-1:0]     bus_b_in = '0;
    logic [DW-1:0]     bus_b_out;
    logic              bus_b_oe, reject, fault, eng_start;
    logic [DW-1:0]     eng_left, eng_leftx, eng_right, eng_rightx, eng_ctrl;
    logic              eng_done = 1'b0;
    logic [DW-1:0]     eng_result = '0;
    logic [DW-1:0]     eng_resultx = '0;
    logic [FLAG_W-1:0] eng_flags = '0;

    int                n_chk = 0;
    int                n_err = 0;
    int                lat = 3;
    logic [FLAG_W-1:0] flag_cfg = '0;
    int                eng_cnt = 0;

    int                last_stalls;
    logic [DW-1:0]     last_out;
    logic              last_oe, last_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    cop_opreg_ctrl #(.DW(DW), .FLAG_W(FLAG_W)) i_cop_opreg_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wrfn(cmd_wrfn), .bus_a_in(bus_a_in), .bus_b_in(bus_b_in),
        .bus_b_out(bus_b_out), .bus_b_oe(bus_b_oe), .reject(reject), .fault(fault),
        .eng_start(eng_start), .eng_left(eng_left), .eng_leftx(eng_leftx),
        .eng_right(eng_right), .eng_rightx(eng_rightx), .eng_ctrl(eng_ctrl),
        .eng_done(eng_done), .eng_result(eng_result), .eng_resultx(eng_resultx),
        .eng_flags(eng_flags)
    );

    // Behavioural engine: restarts on start, answers after lat cycles.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (!rst_n) eng_cnt <= 0;
        else if (eng_start) eng_cnt <= lat;
        else if (eng_cnt == 1) begin
            eng_done    <= 1'b1;
            eng_result  <= eng_left + eng_right;
            eng_resultx <= eng_leftx ^ eng_rightx;
            eng_flags   <= flag_cfg;
            eng_cnt     <= 0;
        end else if (eng_cnt > 1) eng_cnt <= eng_cnt - 1;
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one command, hold it while rejected, capture the final cycle.
    task automatic issue(input logic [3:0] c, input logic wf,
                         input logic [DW-1:0] a, input logic [DW-1:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = c; cmd_wrfn = wf; bus_a_in = a; bus_b_in = b;
        #1;
        last_stalls = 0;
        while (reject && last_stalls < 200) begin
            @(negedge clk); #1;
            last_stalls++;
        end
        last_out = bus_b_out; last_oe = bus_b_oe; last_fault = fault;
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_wrfn = 1'b0;
    endtask

    task automatic rd(input logic [3:0] c);
        issue(c, 1'b0, '0, '0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reject after reset", {31'd0, reject}, 32'd0);
        chk("R1 fault after reset", {31'd0, fault}, 32'd0);
        chk("R1 oe idle", {31'd0, bus_b_oe}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int c = 8; c <= 12; c++) begin
            rd(c[3:0]);
            chk("R1 register cleared", last_out, 32'd0);
        end
    endtask

    task automatic t_single_loads;
        issue(4'd0, 1'b0, 32'hDEAD0000, 32'h11112222);
        rd(4'd8);  chk("R2 code0 Left", last_out, 32'h11112222);
        chk("R4 code8 oe", {31'd0, last_oe}, 32'd1);
        issue(4'd2, 1'b0, 32'hDEAD0000, 32'h33334444);
        rd(4'd10); chk("R2 code2 Right", last_out, 32'h33334444);
        issue(4'd4, 1'b0, 32'hDEAD0000, 32'h00005A33);
        rd(4'd12); chk("R2 code4 Control", last_out, 32'h00005A33);
    endtask

    task automatic t_pair_loads;
        issue(4'd1, 1'b0, 32'hA1A1A1A1, 32'hB1B1B1B1);
        rd(4'd8);  chk("R3 code1 Left", last_out, 32'hB1B1B1B1);
        rd(4'd9);  chk("R3 code1 Leftx", last_out, 32'hA1A1A1A1);
        issue(4'd3, 1'b0, 32'hA3A3A3A3, 32'hB3B3B3B3);
        rd(4'd10); chk("R3 code3 Right", last_out, 32'hB3B3B3B3);
        rd(4'd11); chk("R3 code3 Rightx", last_out, 32'hA3A3A3A3);
        issue(4'd5, 1'b0, 32'h00000014, 32'h0000000A);
        rd(4'd8);  chk("R3 code5 Left", last_out, 32'h0000000A);
        rd(4'd10); chk("R3 code5 Right", last_out, 32'h00000014);
    endtask

    task automatic t_function;
        issue(4'd8, 1'b1, 32'hFFFFFF9C, 32'h0);
        rd(4'd12); chk("R5 function byte only", last_out, 32'h00005A9C);
        issue(4'd4, 1'b1, 32'h00000011, 32'h00000102);
        rd(4'd12); chk("R5 phase-B control wins", last_out, 32'h00000102);
        issue(4'd1, 1'b1, 32'hCAFE0077, 32'h0000000A);
        rd(4'd12); chk("R6 wrfn ignored on code1", last_out, 32'h00000102);
        rd(4'd9);  chk("R6 Leftx from phase A", last_out, 32'hCAFE0077);
    endtask

    // State now: Left=0x0A Leftx=CAFE0077 Right=0x14 Rightx=A3A3A3A3.
    task automatic t_stall;
        lat = 5;
        issue(4'd0, 1'b0, 32'h0, 32'h0000000A);
        issue(4'd14, 1'b0, 32'h0, 32'h0);
        chk("R7 result read stalls", {31'd0, last_stalls > 0}, 32'd1);
        chk("R8 Result value", last_out, 32'h0000001E);
        issue(4'd15, 1'b0, 32'h0, 32'h0);
        chk("R7 ready result not rejected", last_stalls, 32'd0);
        chk("R8 Resultx value", last_out, 32'hCAFE0077 ^ 32'hA3A3A3A3);
    endtask

    task automatic t_operand_reads;
        lat = 8;
        issue(4'd2, 1'b0, 32'h0, 32'h00000014);
        for (int c = 8; c <= 12; c++) begin
            rd(c[3:0]);
            chk("R9 operand read no reject", last_stalls, 32'd0);
        end
        issue(4'd13, 1'b0, 32'h12345678, 32'h87654321);
        chk("R9 code13 drives nothing", {31'd0, last_oe}, 32'd0);
        rd(4'd8);  chk("R9 code13 leaves Left", last_out, 32'h0000000A);
        rd(4'd10); chk("R9 code13 leaves Right", last_out, 32'h00000014);
    endtask

    task automatic t_copy;
        lat = 2;
        issue(4'd6, 1'b0, 32'h0, 32'h0);
        rd(4'd8);  chk("R10 code6 Left", last_out, 32'h0000001E);
        rd(4'd9);  chk("R10 code6 Leftx", last_out, 32'hCAFE0077 ^ 32'hA3A3A3A3);
        issue(4'd14, 1'b0, 32'h0, 32'h0);
        chk("R10 copy restarts", {31'd0, last_stalls > 0}, 32'd1);
        chk("R10 new result", last_out, 32'h00000032);
        issue(4'd7, 1'b0, 32'h0, 32'h0);
        rd(4'd10); chk("R10 code7 Right", last_out, 32'h00000032);
        rd(4'd11); chk("R10 code7 Rightx", last_out, 32'hCAFE0077);
    endtask

    // Left=0x1E Right=0x32.
    task automatic t_flags;
        logic [DW-1:0] left_before;
        lat = 1;
        flag_cfg = 6'b000100;
        issue(4'd4, 1'b0, 32'h0, 32'h00000000);
        issue(4'd14, 1'b0, 32'h0, 32'h0);
        chk("R11 masked flag no fault", {31'd0, last_fault}, 32'd0);
        rd(4'd12); chk("R11 flag merged", last_out, 32'h00040000);
        issue(4'd4, 1'b0, 32'h0, 32'h04000000);
        rd(4'd8);  left_before = last_out;
        issue(4'd6, 1'b0, 32'h0, 32'h0);
        chk("R12 unmasked flag faults", {31'd0, last_fault}, 32'd1);
        rd(4'd8);  chk("R12 fault blocks move", last_out, left_before);
        rd(4'd12); chk("R11 flags after fault", last_out, 32'h04040000);
        issue(4'd14, 1'b0, 32'h0, 32'h0);
        chk("R12 fault no drive", {31'd0, last_oe}, 32'd0);
        chk("R12 fault on result read", {31'd0, last_fault}, 32'd1);
    endtask

    task automatic t_wrfn_result;
        lat = 4;
        flag_cfg = '0;
        issue(4'd4, 1'b0, 32'h0, 32'h00000000);
        issue(4'd14, 1'b0, 32'h0, 32'h0);
        chk("R13 baseline ready", last_out, 32'h00000050);
        issue(4'd14, 1'b1, 32'h00000005, 32'h0);
        chk("R13 function write rejects", {31'd0, last_stalls > 0}, 32'd1);
        chk("R13 read completes", last_out, 32'h00000050);
        rd(4'd12); chk("R13 function written", last_out, 32'h00000005);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        t_reset();
        t_single_loads();
        t_pair_loads();
        t_function();
        t_stall();
        t_operand_reads();
        t_copy();
        t_flags();
        t_wrfn_result();
        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule